// File: doc/BRIEF.md
# Port Controller Message Buffer Window

This block holds the receive and transmit message buffers of a USB Type-C port controller and exposes them to a byte-wide register bus. Each buffer is reached through a single register address. A hidden pointer moves through the buffer behind that address, advancing once per access. A receive window read returns the stored byte count first, then the frame type, then the payload bytes. A transmit window write takes the byte count first, then the header and data bytes.

Software starts a send by writing a control register that carries the frame type and the retry count. Two command codes move the hidden pointers back. The transmit rewind always returns to offset 1. The receive rewind returns to offset 1 or to the start of the second transaction-sized half, depending on where the pointer stands, so that a long message can be re-read in bus-sized pieces.

The physical-layer side is a simple byte stream of received frames, plus a launch strobe, a random-access byte port into the transmit buffer and a completion strobe with a result code. The block sets the alert bits for a stored message, a receive overflow and the three transmit outcomes. Software clears those bits by writing ones.

Top module: `pdmsg_window`

## Requirements
- R1: After reset every alert bit reads 0, `irq` is 0, `tx_busy` and `tx_go` are 0, and a read of the receive window (address 0x30) returns 0.
- R2: While a message is held, successive reads of 0x30 return the count byte (payload length + 1), then the frame type in bits 2:0, then the payload bytes in arrival order, one per read.
- R3: Reads of 0x30 past the held count return 0. The window pointer stops at the last buffer byte (index RX_BYTES+1) and repeats it. Payload bytes beyond RX_BYTES are dropped. The count byte saturates at 0xFF.
- R4: Bits 4:0 of the detect register (address 0x2F, read/write, reset 0) enable reception of frame types 0 to 4 (bit n for type n). A frame of a disabled type, or of type 5, 6 or 7, is dropped and raises no alert.
- R5: An accepted frame sets alert bit 2 in the cycle after its end strobe. An enabled frame that starts while bit 2 is set is not stored, leaves the held message intact and sets alert bit 10 (bit 2 of address 0x11).
- R6: The alert register reads bits 7:0 at 0x10 and bits 15:8 at 0x11. Writing 1 to a bit clears it and writing 0 leaves it. Clearing bit 2 frees the receive buffer, and the window then reads 0.
- R7: Writing 0xEE to the command register (0x23) moves the receive pointer to 1 if it is at RX_SPLIT (132) or below, and to RX_SPLIT+1 (133) otherwise.
- R8: Writes to 0x51 fill the transmit buffer from pointer 0 upward: count at index 0, then bytes at 1, 2, and so on. The pointer stops at TX_BYTES+1, where writes are discarded. The physical side reads index `tx_rd_idx` on `tx_rd_byte`, and an index past TX_BYTES reads 0.
- R9: Writing 0xDD to the command register moves the transmit pointer to 1, so the next write lands at index 1 and the count byte is kept.
- R10: A write to 0x50 while idle gives a one-cycle `tx_go` in the next cycle. It latches `tx_kind` from bits 2:0 and `tx_retries` from bits 7:4, sets `tx_busy` and returns the transmit pointer to 0. A write to 0x50 while busy is ignored.
- R11: `tx_done` while busy clears `tx_busy` and sets one alert bit by `tx_result`: 0 sets bit 6, 1 sets bit 5, and 2 or 3 set bit 4. `tx_done` while idle has no effect.
- R12: `irq` is 1 exactly when some alert bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the receive window) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_sof | input | 1 | Start of a received frame |
| rx_type | input | 3 | Frame type, valid with `rx_sof` |
| rx_vld | input | 1 | Received payload byte valid |
| rx_byte | input | 8 | Received payload byte |
| rx_eof | input | 1 | End of a received frame (never with `rx_vld`) |
| tx_go | output | 1 | One-cycle send launch |
| tx_kind | output | 3 | Frame type of the launched send |
| tx_retries | output | 4 | Retry count of the launched send |
| tx_busy | output | 1 | A send is in flight |
| tx_rd_idx | input | TXI_W | Transmit buffer index read by the physical side |
| tx_rd_byte | output | 8 | Transmit buffer byte at `tx_rd_idx` |
| tx_done | input | 1 | Send completion strobe |
| tx_result | input | 2 | Completion result: 0 success, 1 discarded, 2/3 failed |
| irq | output | 1 | Any alert bit set |

## Verification
On every cycle the assertions check that both hidden pointers stay inside their buffers. They also check that each rewind command lands on one of its legal offsets, that an overflow or a stored frame shows up in the alert register one cycle later, and that a launch never happens without the busy flag. The read order of the receive window, the zero fill past the count, the exact choice between offsets 1 and 133, the dropping of disabled types and the result-to-bit mapping depend on whole frames and command sequences. Only the bench scenarios show those, including a 270-byte frame that drives the pointer past the split point and into saturation.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
   localparam logic [7:0] A_ALERT_LO = 8'h10;
   localparam logic [7:0] A_ALERT_HI = 8'h11;
   localparam logic [7:0] A_CMD      = 8'h23;
   localparam logic [7:0] A_DETECT   = 8'h2F;
   localparam logic [7:0] A_RXWIN    = 8'h30;
   localparam logic [7:0] A_TXCTL    = 8'h50;
   localparam logic [7:0] A_TXWIN    = 8'h51;

   localparam logic [7:0] CMD_TX_REWIND = 8'hDD;
   localparam logic [7:0] CMD_RX_REWIND = 8'hEE;

   localparam int ALERT_W    = 16;
   localparam int B_RX_DONE  = 2;
   localparam int B_TX_FAIL  = 4;
   localparam int B_TX_DROP  = 5;
   localparam int B_TX_OK    = 6;
   localparam int B_RX_OVF   = 10;
   localparam int N_MSG_TYPES = 5;

   typedef enum logic [1:0] {
      TXR_OK      = 2'd0,
      TXR_DISCARD = 2'd1,
      TXR_FAIL    = 2'd2,
      TXR_ABORT   = 2'd3
   } tx_result_e;
endpackage

// File: rtl/pdw_rx_buf.sv
module pdw_rx_buf #(
   parameter int RX_BYTES = 264,
   parameter int RX_SPLIT = 132
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sof,
   input  logic [2:0] ftype,
   input  logic       vld,
   input  logic [7:0] din,
   input  logic       eof,
   input  logic [4:0] type_en,
   input  logic       held,
   input  logic       rd_adv,
   input  logic       rewind,
   output logic       done_hit,
   output logic       ovf_hit,
   output logic [7:0] rd_byte
);
   localparam int IW   = $clog2(RX_BYTES + 2);
   localparam int LW   = $clog2(RX_BYTES + 1);
   localparam int AW   = $clog2(RX_BYTES);
   localparam int LAST = RX_BYTES + 1;

   if (RX_BYTES < 2)           begin : g_chk_depth $error("RX_BYTES too small"); end
   if (RX_SPLIT + 1 > LAST)    begin : g_chk_split $error("RX_SPLIT beyond buffer"); end

   logic [7:0]    mem [RX_BYTES];
   logic [LW-1:0] wr_len, held_len;
   logic [2:0]    cap_type, held_type;
   logic          capturing;
   logic [IW-1:0] rptr;
   logic          accept;

   assign accept   = (ftype < 3'd5) && ({3'b000, type_en} >> ftype) != 8'd0
                     && type_en[ftype[2] ? 3'd4 : ftype];
   assign ovf_hit  = sof && accept && held;
   assign done_hit = eof && capturing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         capturing <= 1'b0;
         wr_len    <= '0;
         held_len  <= '0;
         cap_type  <= '0;
         held_type <= '0;
      end else begin
         if (sof) begin
            capturing <= accept && !held;
            wr_len    <= '0;
            cap_type  <= ftype;
         end else if (vld && capturing && wr_len < LW'(RX_BYTES)) begin
            wr_len <= wr_len + 1'b1;
         end
         if (done_hit) begin
            capturing <= 1'b0;
            held_len  <= wr_len;
            held_type <= cap_type;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!sof && vld && capturing && wr_len < LW'(RX_BYTES))
         mem[wr_len[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rptr <= '0;
      else if (done_hit)          rptr <= '0;
      else if (rewind)            rptr <= (rptr <= IW'(RX_SPLIT)) ? IW'(1) : IW'(RX_SPLIT + 1);
      else if (rd_adv && rptr != IW'(LAST)) rptr <= rptr + 1'b1;
   end

   logic [15:0]   len_p1;
   logic [IW-1:0] didx;
   assign len_p1 = 16'(held_len) + 16'd1;
   assign didx   = rptr - IW'(2);

   always_comb begin
      rd_byte = 8'h00;
      if (held) begin
         if (rptr == '0)
            rd_byte = (len_p1 > 16'd255) ? 8'hFF : len_p1[7:0];
         else if (rptr == IW'(1))
            rd_byte = {5'b0, held_type};
         else if (16'(didx) < 16'(held_len))
            rd_byte = mem[didx[AW-1:0]];
      end
   end

   a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rptr <= IW'(LAST));
   a_r7_rewind_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !done_hit) |=> (rptr == IW'(1) || rptr == IW'(RX_SPLIT + 1)));
   a_r5_full_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && held) |=> !capturing);
endmodule

// File: rtl/pdw_tx_buf.sv
module pdw_tx_buf #(
   parameter int TX_BYTES = 132,
   parameter int IW       = $clog2(TX_BYTES + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [7:0]    wdata,
   input  logic          rewind,
   input  logic          restart,
   input  logic [IW-1:0] rd_idx,
   output logic [7:0]    rd_byte
);
   localparam int LAST_W = TX_BYTES + 1;
   localparam int AW     = $clog2(TX_BYTES + 1);

   if (TX_BYTES < 1)            begin : g_chk_depth $error("TX_BYTES too small"); end
   if (IW < $clog2(TX_BYTES + 2)) begin : g_chk_iw  $error("index width too narrow"); end

   logic [7:0]    mem [TX_BYTES + 1];
   logic [IW-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ptr <= '0;
      else if (restart)                         ptr <= '0;
      else if (rewind)                          ptr <= IW'(1);
      else if (wr && ptr != IW'(LAST_W))        ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!restart && !rewind && wr && ptr != IW'(LAST_W))
         mem[ptr[AW-1:0]] <= wdata;
   end

   assign rd_byte = (rd_idx <= IW'(TX_BYTES)) ? mem[rd_idx[AW-1:0]] : 8'h00;

   a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= IW'(LAST_W));
   a_r9_rewind_one: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !restart) |=> ptr == IW'(1));
   a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> ptr == '0);
endmodule

// File: rtl/pdmsg_window.sv
module pdmsg_window
   import pdw_pkg::*;
#(
   parameter int RX_BYTES = 264,
   parameter int RX_SPLIT = 132,
   parameter int TX_BYTES = 132,
   localparam int TXI_W   = $clog2(TX_BYTES + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             rx_sof,
   input  logic [2:0]       rx_type,
   input  logic             rx_vld,
   input  logic [7:0]       rx_byte,
   input  logic             rx_eof,
   output logic             tx_go,
   output logic [2:0]       tx_kind,
   output logic [3:0]       tx_retries,
   output logic             tx_busy,
   input  logic [TXI_W-1:0] tx_rd_idx,
   output logic [7:0]       tx_rd_byte,
   input  logic             tx_done,
   input  logic [1:0]       tx_result,
   output logic             irq
);
   logic [ALERT_W-1:0] alert_q, set_v, clr_v;
   logic [4:0]         detect_q;
   logic               cmd_wr, rx_rewind, tx_rewind, launch, done_acc;
   logic               rx_done_hit, rx_ovf_hit;
   logic [7:0]         rx_rd;

   assign cmd_wr    = bus_wr && bus_addr == A_CMD;
   assign rx_rewind = cmd_wr && bus_wdata == CMD_RX_REWIND;
   assign tx_rewind = cmd_wr && bus_wdata == CMD_TX_REWIND;
   assign launch    = bus_wr && bus_addr == A_TXCTL && !tx_busy;
   assign done_acc  = tx_done && tx_busy;

   pdw_rx_buf #(.RX_BYTES(RX_BYTES), .RX_SPLIT(RX_SPLIT)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .sof(rx_sof), .ftype(rx_type), .vld(rx_vld), .din(rx_byte), .eof(rx_eof),
      .type_en(detect_q), .held(alert_q[B_RX_DONE]),
      .rd_adv(bus_rd && bus_addr == A_RXWIN), .rewind(rx_rewind),
      .done_hit(rx_done_hit), .ovf_hit(rx_ovf_hit), .rd_byte(rx_rd)
   );

   pdw_tx_buf #(.TX_BYTES(TX_BYTES), .IW(TXI_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr && bus_addr == A_TXWIN), .wdata(bus_wdata),
      .rewind(tx_rewind), .restart(launch),
      .rd_idx(tx_rd_idx), .rd_byte(tx_rd_byte)
   );

   always_comb begin
      set_v = '0;
      set_v[B_RX_DONE] = rx_done_hit;
      set_v[B_RX_OVF]  = rx_ovf_hit;
      if (done_acc) begin
         case (tx_result_e'(tx_result))
            TXR_OK:      set_v[B_TX_OK]   = 1'b1;
            TXR_DISCARD: set_v[B_TX_DROP] = 1'b1;
            default:     set_v[B_TX_FAIL] = 1'b1;
         endcase
      end
      clr_v = '0;
      if (bus_wr && bus_addr == A_ALERT_LO) clr_v[7:0]  = bus_wdata;
      if (bus_wr && bus_addr == A_ALERT_HI) clr_v[15:8] = bus_wdata;
   end

   for (genvar b = 0; b < ALERT_W; b++) begin : g_alert
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) alert_q[b] <= 1'b0;
         else        alert_q[b] <= set_v[b] | (alert_q[b] & ~clr_v[b]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         detect_q   <= '0;
         tx_go      <= 1'b0;
         tx_kind    <= '0;
         tx_retries <= '0;
         tx_busy    <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == A_DETECT) detect_q <= bus_wdata[4:0];
         tx_go <= launch;
         if (launch) begin
            tx_kind    <= bus_wdata[2:0];
            tx_retries <= bus_wdata[7:4];
            tx_busy    <= 1'b1;
         end else if (done_acc) begin
            tx_busy <= 1'b0;
         end
      end
   end

   always_comb begin
      case (bus_addr)
         A_ALERT_LO: bus_rdata = alert_q[7:0];
         A_ALERT_HI: bus_rdata = alert_q[15:8];
         A_DETECT:   bus_rdata = {3'b000, detect_q};
         A_RXWIN:    bus_rdata = rx_rd;
         default:    bus_rdata = 8'h00;
      endcase
   end

   assign irq = |alert_q;

   a_r5_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf_hit |=> alert_q[B_RX_OVF]);
   a_r5_stored_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_hit |=> alert_q[B_RX_DONE]);
   a_r10_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> tx_busy);
   a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && bus_wr && bus_addr == A_TXCTL) |=> ($stable(tx_kind) && !tx_go));
   a_r11_ok_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && tx_busy && tx_result == 2'd0) |=> (alert_q[B_TX_OK] && !tx_busy));
endmodule

// File: tb/pdmsg_window_tb.sv
module pdmsg_window_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
   logic       rx_sof = 0, rx_vld = 0, rx_eof = 0;
   logic [2:0] rx_type = 0;
   logic [7:0] rx_byte = 0;
   logic       tx_go, tx_busy, irq;
   logic [2:0] tx_kind;
   logic [3:0] tx_retries;
   logic [7:0] tx_rd_idx = 0, tx_rd_byte;
   logic       tx_done = 0;
   logic [1:0] tx_result = 0;

   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   pdmsg_window u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_sof(rx_sof), .rx_type(rx_type), .rx_vld(rx_vld), .rx_byte(rx_byte),
      .rx_eof(rx_eof), .tx_go(tx_go), .tx_kind(tx_kind), .tx_retries(tx_retries),
      .tx_busy(tx_busy), .tx_rd_idx(tx_rd_idx), .tx_rd_byte(tx_rd_byte),
      .tx_done(tx_done), .tx_result(tx_result), .irq(irq)
   );

   // {detect, type, length, expect_stored}
   localparam logic [31:0] VEC [6] = '{
      32'h01_00_05_01, 32'h02_01_03_01, 32'h1F_04_1E_01,
      32'h1D_01_04_00, 32'h1F_05_02_00, 32'h10_04_00_01 };

   function automatic logic [7:0] pat(input int s, input int j);
      return 8'(s + j * 7);
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1 bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
      @(posedge clk); #1 bus_rd = 0;
   endtask

   task automatic frame(input logic [2:0] t, input int len, input int seed);
      @(negedge clk); rx_sof = 1; rx_type = t;
      @(posedge clk); #1 rx_sof = 0;
      for (int j = 0; j < len; j++) begin
         @(negedge clk); rx_vld = 1; rx_byte = pat(seed, j);
         @(posedge clk); #1 rx_vld = 0;
      end
      @(negedge clk); rx_eof = 1;
      @(posedge clk); #1 rx_eof = 0;
   endtask

   task automatic finish_tx(input logic [1:0] r);
      @(negedge clk); tx_done = 1; tx_result = r;
      @(posedge clk); #1 tx_done = 0;
   endtask

   task automatic peek_tx(input logic [7:0] idx, output logic [7:0] d);
      @(negedge clk); tx_rd_idx = idx; #1 d = tx_rd_byte;
   endtask

   task automatic run_tests;
      logic [7:0] d;
      // R1 reset state
      rst_n = 0; repeat (3) @(posedge clk); #1 rst_n = 1;
      rd(8'h10, d); chk("R1 alert lo", d, 0);
      rd(8'h11, d); chk("R1 alert hi", d, 0);
      rd(8'h30, d); chk("R1 window empty", d, 0);
      chk("R1 busy", tx_busy, 0); chk("R1 go", tx_go, 0); chk("R12 irq idle", irq, 0);

      // Vector table: R2, R3, R4, R5, R6
      for (int i = 0; i < 6; i++) begin
         logic [7:0] det, ty, ln;
         logic stored;
         det = VEC[i][31:24]; ty = VEC[i][23:16]; ln = VEC[i][15:8]; stored = VEC[i][0];
         wr(8'h2F, det);
         frame(ty[2:0], int'(ln), 16 * i + 3);
         rd(8'h10, d); chk("R4/R5 stored flag", d, stored ? 8'h04 : 8'h00);
         if (stored) begin
            chk("R12 irq set", irq, 1);
            rd(8'h30, d); chk("R2 count", d, int'(ln) + 1);
            rd(8'h30, d); chk("R2 type", d, int'(ty));
            for (int j = 0; j < int'(ln); j++) begin
               rd(8'h30, d); chk("R2 payload", d, pat(16 * i + 3, j));
            end
            rd(8'h30, d); chk("R3 past count", d, 0);
            wr(8'h10, 8'h04);
            rd(8'h30, d); chk("R6 freed window", d, 0);
         end
      end

      // R5 overflow keeps held message
      wr(8'h2F, 8'h1F);
      frame(3'd0, 3, 90);
      frame(3'd2, 2, 120);
      rd(8'h10, d); chk("R5 rx flag", d, 8'h04);
      rd(8'h11, d); chk("R5 overflow flag", d, 8'h04);
      rd(8'h30, d); chk("R5 held count", d, 4);
      rd(8'h30, d); chk("R5 held type", d, 0);
      rd(8'h30, d); chk("R5 held byte", d, pat(90, 0));
      wr(8'h11, 8'h04);
      rd(8'h11, d); chk("R6 w1c hi", d, 0);
      rd(8'h10, d); chk("R6 zero write keeps", d, 8'h04);
      wr(8'h10, 8'h04);
      @(negedge clk); chk("R12 irq cleared", irq, 0);
      // disabled type while full gives no overflow
      wr(8'h2F, 8'h01);
      frame(3'd0, 1, 5);
      frame(3'd1, 1, 6);
      rd(8'h11, d); chk("R4 disabled no overflow", d, 0);
      wr(8'h10, 8'h04);

      // R7 rewind low half
      wr(8'h2F, 8'h1F);
      frame(3'd3, 10, 40);
      for (int j = 0; j < 5; j++) rd(8'h30, d);
      wr(8'h23, 8'hEE);
      rd(8'h30, d); chk("R7 rewind to 1 (type)", d, 3);
      rd(8'h30, d); chk("R7 after rewind byte0", d, pat(40, 0));
      wr(8'h10, 8'h04);

      // R7 rewind high half, R3 truncation and saturation
      frame(3'd0, 270, 11);
      rd(8'h30, d); chk("R3 count saturates", d, 8'hFF);
      rd(8'h30, d);
      for (int j = 0; j < 138; j++) rd(8'h30, d);
      chk("R2 long byte 137", d, pat(11, 137));
      wr(8'h23, 8'hEE);
      rd(8'h30, d); chk("R7 rewind to 133", d, pat(11, 131));
      for (int j = 0; j < 200; j++) rd(8'h30, d);
      chk("R3 pointer holds last byte", d, pat(11, 263));
      rd(8'h30, d); chk("R3 extra bytes dropped", d, pat(11, 263));
      wr(8'h10, 8'h04);

      // R8 transmit fill, R9 rewind
      wr(8'h51, 8'h03); wr(8'h51, 8'hAA); wr(8'h51, 8'hBB); wr(8'h51, 8'hCC);
      peek_tx(0, d); chk("R8 count idx0", d, 3);
      peek_tx(3, d); chk("R8 idx3", d, 8'hCC);
      peek_tx(200, d); chk("R8 idx beyond zero", d, 0);
      wr(8'h23, 8'hDD); wr(8'h51, 8'h11);
      peek_tx(1, d); chk("R9 rewrite idx1", d, 8'h11);
      peek_tx(0, d); chk("R9 count kept", d, 3);

      // R10 launch
      wr(8'h50, 8'h35);
      @(negedge clk);
      chk("R10 go pulse", tx_go, 1); chk("R10 kind", tx_kind, 5);
      chk("R10 retries", tx_retries, 3); chk("R10 busy", tx_busy, 1);
      @(negedge clk); chk("R10 go one cycle", tx_go, 0);
      wr(8'h50, 8'h12);
      @(negedge clk); chk("R10 busy launch ignored go", tx_go, 0);
      chk("R10 busy launch ignored kind", tx_kind, 5);
      finish_tx(2'd1);
      rd(8'h10, d); chk("R11 discarded bit5", d, 8'h20);
      chk("R11 busy cleared", tx_busy, 0);
      wr(8'h10, 8'h20);

      // R8 saturation after launch restart
      for (int k = 0; k < 135; k++) wr(8'h51, 8'(k) ^ 8'h3C);
      peek_tx(0, d); chk("R10 ptr restart idx0", d, 8'h3C);
      peek_tx(132, d); chk("R8 saturated last", d, 8'(132) ^ 8'h3C);

      // R11 other results
      wr(8'h50, 8'h00); finish_tx(2'd0);
      rd(8'h10, d); chk("R11 success bit6", d, 8'h40); wr(8'h10, 8'h40);
      wr(8'h50, 8'h01); finish_tx(2'd2);
      rd(8'h10, d); chk("R11 failed bit4", d, 8'h10); wr(8'h10, 8'h10);
      wr(8'h50, 8'h01); finish_tx(2'd3);
      rd(8'h10, d); chk("R11 result3 bit4", d, 8'h10); wr(8'h10, 8'h10);
      finish_tx(2'd0);
      rd(8'h10, d); chk("R11 idle done ignored", d, 0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule